// File: doc/BRIEF.md
# Cascadable Triple Reload Timer

This block contains three 8-bit down-counters. Each counter has its own reload latch, and all three share one mode register. Software reaches the block through a small register bus: an address, a write strobe, write data, and combinational read data. Each counter steps down once per tick of its selected source. When a counter steps past zero it reloads from its latch and raises a one-cycle underflow pulse, so the period is the latch value plus one ticks.

There are two base tick sources:

- **Divided tick.** A divide-by-16 prescaler produces it. The prescaler counts system clocks, or counts sub-clock rising edges when the low-speed flag is set.
- **Sub-clock tick.** The slow sub-clock input is synchronised into the system clock domain and edge-detected, which gives one tick per rising edge.

Timer 1 counts either base source. Timers 2 and 3 count either timer 1 underflows or the divided tick. Every tick is a single-cycle enable in the system clock domain, so changing a source selection cannot create a stray count.

Timer 2 has two write behaviours. It can load the counter and the latch together, or it can load the latch only, in which case the counter picks up the new value at its next underflow. Timer 2 underflows also drive a toggle output whose starting level is selectable.

Top module: `triple_reload_timer`

## Requirements
- R1: After reset, the mode register and all three counters read 0 and `tout` is 0.
- R2: Read map: address 0 returns the mode register, addresses 1, 2 and 3 return the timer 1, 2 and 3 counters, and any other address returns 0. Mode bits 7 and 6 always read 0.
- R3: On each tick of its source, a counter decrements. A counter at 0x00 instead reloads its latch and emits a one-cycle underflow pulse. The period is therefore latch + 1 ticks.
- R4: Mode bit 5 selects the timer 1 source. At 0 it is the divided tick; at 1 it is each rising edge of `sub_clk`, taken after a two-stage synchroniser.
- R5: Mode bit 3 selects the timer 2 source and mode bit 4 selects the timer 3 source. At 0 the source is timer 1 underflows; at 1 it is the divided tick.
- R6: The divided tick occurs once every 16 system clocks when `low_speed` is 0, and once every 16 sub-clock rising edges when `low_speed` is 1.
- R7: A write to address 1 or 3 loads both the counter and the latch of that timer.
- R8: When mode bit 2 is 0, a write to address 2 loads both the timer 2 counter and its latch.
- R9: When mode bit 2 is 1, a write to address 2 loads only the latch. The counter is unchanged apart from normal counting, and it takes the new value at the next underflow.
- R10: A mode register write leaves every latch and counter value unchanged, apart from normal counting.
- R11: When mode bit 1 is 1, `tout` inverts one cycle after each timer 2 underflow and changes at no other time while the mode register is unchanged.
- R12: When mode bit 1 is 0, `tout` is 0. At the moment the output is enabled, `tout` starts high if mode bit 0 is 0 and low if mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sub_clk | input | 1 | Slow sub-clock, asynchronous to `clk` |
| low_speed | input | 1 | Prescaler counts sub-clock edges instead of system clocks |
| tout | output | 1 | Timer 2 toggle output |

## Verification
The bench builds the block with its default parameters: 8-bit counters, a 4-bit prescaler (divide by 16) and a two-stage synchroniser. With these values, every period is a short, exact product of 16, the sub-clock spacing and the two latch values. That makes underflow intervals measured on `tout` directly comparable with bench-computed periods, for both the cascaded and the direct sources. Counter differences read over fixed windows pin down tick rates. Reads taken right around a timer 2 write show whether the counter was loaded or left alone.

// File: rtl/timer_pkg.sv
// Package: shared register addresses and the mode register layout for the
// triple reload timer. Assumes a 3-bit address and an 8-bit mode register.
package timer_pkg;

    localparam logic [2:0] ADDR_MODE = 3'd0;
    localparam logic [2:0] ADDR_T1   = 3'd1;
    localparam logic [2:0] ADDR_T2   = 3'd2;
    localparam logic [2:0] ADDR_T3   = 3'd3;

    // Mode register, MSB first: bits 7:6 reserved, then sources, then output.
    typedef struct packed {
        logic [1:0] rsvd;          // bits 7:6, always zero
        logic       t1_sub;        // bit 5: timer 1 counts sub-clock edges
        logic       t3_div;        // bit 4: timer 3 counts divided tick
        logic       t2_div;        // bit 3: timer 2 counts divided tick
        logic       t2_latch_only; // bit 2: timer 2 writes go to latch only
        logic       out_en;        // bit 1: toggle output enabled
        logic       start_low;     // bit 0: output starts low when enabled
    } mode_t;

endpackage

// File: rtl/tick_gen.sv
// tick_gen: brings the asynchronous sub-clock into the clk domain, detects
// its rising edges, and runs the divide-by-2^PRESC_BITS prescaler.
// Assumes the sub-clock is much slower than clk (each level lasts at least
// two clk cycles). Both outputs are single-cycle enables.
module tick_gen #(
    parameter int PRESC_BITS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_clk,
    input  logic low_speed,
    output logic sub_pulse,
    output logic div_pulse
);
    localparam int SMSB = SYNC_STAGES - 1;

    logic [SMSB:0]           sync_q;
    logic                    sub_prev_q;
    logic [PRESC_BITS-1:0]   presc_q;
    logic                    presc_step;

    // Synchroniser chain and previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= '0;
            sub_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SMSB-1:0], sub_clk};
            sub_prev_q <= sync_q[SMSB];
        end
    end

    assign sub_pulse  = sync_q[SMSB] & ~sub_prev_q;
    assign presc_step = low_speed ? sub_pulse : 1'b1;

    // Prescaler: advances per clock, or per sub-clock edge in low-speed mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_q <= '0;
        else if (presc_step)
            presc_q <= presc_q + 1'b1;
    end

    assign div_pulse = presc_step && (presc_q == '1);
endmodule

// File: rtl/reload_counter.sv
// reload_counter: a down-counter with a separate reload latch. On a tick at
// zero it reloads and pulses underflow for one cycle. load_both writes the
// counter and the latch; load_latch writes the latch only. Assumes load_both
// and load_latch are never high together.
module reload_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_both,
    input  logic         load_latch,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] latch_q,
    output logic         underflow
);
    logic [W-1:0] reload_val;
    logic         at_zero;

    assign at_zero    = (count == '0);
    assign reload_val = load_latch ? wdata : latch_q;

    // Reload latch: updated by either kind of write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (load_both || load_latch)
            latch_q <= wdata;
    end

    // Counter: a direct write wins over counting; a tick decrements or reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_both)
            count <= wdata;
        else if (tick)
            count <= at_zero ? reload_val : count - 1'b1;
    end

    // Underflow pulse: one cycle, registered alongside the reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            underflow <= 1'b0;
        else
            underflow <= tick && at_zero && !load_both;
    end
endmodule

// File: rtl/triple_reload_timer.sv
// triple_reload_timer: three reload timers sharing one mode register.
// Timer 1 counts the divided tick or sub-clock edges; timers 2 and 3 count
// timer 1 underflows or the divided tick. Timer 2 drives a toggle output.
// Assumes single-cycle wr_en strobes; rdata is combinational.
module triple_reload_timer
    import timer_pkg::*;
#(
    parameter int W           = 8,
    parameter int PRESC_BITS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   addr,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         sub_clk,
    input  logic         low_speed,
    output logic         tout
);
    mode_t        mode_q;
    logic         sub_pulse, div_pulse;
    logic         t1_tick, t2_tick, t3_tick;
    logic         t1_uf, t2_uf, t3_uf;
    logic [W-1:0] t1_count, t2_count, t3_count;
    logic [W-1:0] t1_latch, t2_latch, t3_latch;
    logic         wr_mode, wr_t1, wr_t2, wr_t3;
    logic         parity_q;

    assign wr_mode = wr_en && (addr == ADDR_MODE);
    assign wr_t1   = wr_en && (addr == ADDR_T1);
    assign wr_t2   = wr_en && (addr == ADDR_T2);
    assign wr_t3   = wr_en && (addr == ADDR_T3);

    // Mode register: reserved bits are forced to zero on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= mode_t'({2'b00, wdata[5:0]});
    end

    tick_gen #(
        .PRESC_BITS  (PRESC_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_clk   (sub_clk),
        .low_speed (low_speed),
        .sub_pulse (sub_pulse),
        .div_pulse (div_pulse)
    );

    assign t1_tick = mode_q.t1_sub ? sub_pulse : div_pulse;
    assign t2_tick = mode_q.t2_div ? div_pulse : t1_uf;
    assign t3_tick = mode_q.t3_div ? div_pulse : t1_uf;

    reload_counter #(.W(W)) u_t1 (
        .clk (clk), .rst_n (rst_n), .tick (t1_tick),
        .load_both (wr_t1), .load_latch (1'b0), .wdata (wdata),
        .count (t1_count), .latch_q (t1_latch), .underflow (t1_uf)
    );

    reload_counter #(.W(W)) u_t2 (
        .clk (clk), .rst_n (rst_n), .tick (t2_tick),
        .load_both (wr_t2 && !mode_q.t2_latch_only),
        .load_latch (wr_t2 && mode_q.t2_latch_only), .wdata (wdata),
        .count (t2_count), .latch_q (t2_latch), .underflow (t2_uf)
    );

    reload_counter #(.W(W)) u_t3 (
        .clk (clk), .rst_n (rst_n), .tick (t3_tick),
        .load_both (wr_t3), .load_latch (1'b0), .wdata (wdata),
        .count (t3_count), .latch_q (t3_latch), .underflow (t3_uf)
    );

    // Toggle parity: cleared while disabled, flips on each timer 2 underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            parity_q <= 1'b0;
        else if (!mode_q.out_en)
            parity_q <= 1'b0;
        else if (t2_uf)
            parity_q <= ~parity_q;
    end

    assign tout = mode_q.out_en & (parity_q ^ ~mode_q.start_low);

    // Read mux for the register map.
    always_comb begin
        case (addr)
            ADDR_MODE: rdata = W'(mode_q);
            ADDR_T1:   rdata = t1_count;
            ADDR_T2:   rdata = t2_count;
            ADDR_T3:   rdata = t3_count;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/triple_reload_timer_checker.sv
// triple_reload_timer_checker: temporal properties of the timer block,
// attached to every instance of the top module by the bind below.
module triple_reload_timer_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   addr,
    input logic         wr_en,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic         tout,
    input logic [7:0]   mode_q,
    input logic [W-1:0] t1_count,
    input logic [W-1:0] t1_latch,
    input logic [W-1:0] t2_count,
    input logic [W-1:0] t2_latch,
    input logic [W-1:0] t3_latch,
    input logic         t1_uf,
    input logic         t2_uf,
    input logic         t2_tick
);
    // Reserved mode bits read as zero.
    p_mode_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd0) |-> (rdata[7:6] == 2'b00));

    // An underflow pulse never lasts two cycles.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        t1_uf |=> !t1_uf);

    // On underflow the timer 2 counter holds the latch value.
    p_reload_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_uf && !$past(wr_en)) |-> (t2_count == $past(t2_latch)));

    // Timer 1 write loads counter and latch.
    p_t1_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=>
            (t1_count == $past(wdata) && t1_latch == $past(wdata)));

    // Direct timer 2 write loads the counter.
    p_t2_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && !mode_q[2]) |=> (t2_count == $past(wdata)));

    // Latch-only timer 2 write leaves an idle counter alone.
    p_t2_latch_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && mode_q[2] && !t2_tick) |=>
            ($stable(t2_count) && t2_latch == $past(wdata)));

    // Mode writes keep every latch.
    p_mode_keeps_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=>
            ($stable(t1_latch) && $stable(t2_latch) && $stable(t3_latch)));

    // Output changes only after a timer 2 underflow while mode is steady.
    p_tout_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_q) && tout != $past(tout)) |-> $past(t2_uf));

    // Enabling the output starts it at the selected level.
    p_tout_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q[1]) |-> (tout == !mode_q[0]));
endmodule

bind triple_reload_timer triple_reload_timer_checker #(.W(W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .tout     (tout),
    .mode_q   (mode_q),
    .t1_count (t1_count),
    .t1_latch (t1_latch),
    .t2_count (t2_count),
    .t2_latch (t2_latch),
    .t3_latch (t3_latch),
    .t1_uf    (t1_uf),
    .t2_uf    (t2_uf),
    .t2_tick  (t2_tick)
);

// File: tb/triple_reload_timer_bench.sv
// Bench for triple_reload_timer: directed corner cases plus seeded random
// cascade configurations, checked against periods computed by functions.
module triple_reload_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       sub_clk = 1'b0;
    logic       low_speed = 1'b0;
    logic       tout;
    logic       sub_run = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    triple_reload_timer u_triple_reload_timer (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wdata (wdata), .rdata (rdata), .sub_clk (sub_clk),
        .low_speed (low_speed), .tout (tout)
    );

    // Sub-clock: toggles every 5 system clocks when running (period 10).
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            if (sub_run) sub_clk = ~sub_clk;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            bad = bad + 1;
            total = total + 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int cascade_period(int l1, int l2, bit t2_div, int unit);
        if (t2_div) return (l2 + 1) * unit;
        return (l1 + 1) * (l2 + 1) * unit;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read at the current time (called right after a negedge).
    task automatic rd_now(logic [2:0] a, output int v);
        addr = a;
        #0.5;
        v = int'(rdata);
    endtask

    // Count clocks until tout differs from its current level.
    task automatic wait_toggle(output int n);
        logic start;
        start = tout;
        n = 0;
        while (tout == start && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(output int n);
        int dummy;
        wait_toggle(dummy);
        wait_toggle(dummy);
        wait_toggle(n);
    endtask

    initial begin
        int v, w, n, exp;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        for (int a = 0; a < 4; a++) begin
            rd_now(3'(a), v);
            check(v == 0, "R1 reset read", v, 0);
        end
        check(tout == 1'b0, "R1 reset tout", int'(tout), 0);

        // R2: unused address and reserved mode bits.
        rd_now(3'd6, v);
        check(v == 0, "R2 unused address", v, 0);
        wr(3'd0, 8'hFF);
        rd_now(3'd0, v);
        check(v == 8'h3F, "R2 mode readback", v, 8'h3F);
        wr(3'd0, 8'h00);

        // R7/R6/R4: timer 1 on divided tick decrements once per 16 clocks.
        wr(3'd1, 8'd100);
        rd_now(3'd1, v);
        check(v == 100 || v == 99, "R7 t1 load", v, 100);
        rd_now(3'd1, v);
        repeat (160) @(negedge clk);
        rd_now(3'd1, w);
        check(v - w == 10, "R6 divided tick rate", v - w, 10);

        // R5: timer 3 from timer 1 underflows (t1 period 64 clocks).
        wr(3'd1, 8'd3);
        wr(3'd3, 8'd200);
        rd_now(3'd3, v);
        repeat (640) @(negedge clk);
        rd_now(3'd3, w);
        check(v - w == 10, "R5 t3 cascaded rate", v - w, 10);

        // R5: timer 3 on divided tick.
        wr(3'd0, 8'h10);
        rd_now(3'd3, v);
        repeat (160) @(negedge clk);
        rd_now(3'd3, w);
        check(v - w == 10, "R5 t3 divided rate", v - w, 10);

        // R10: mode write leaves timer 3 value intact.
        rd_now(3'd3, v);
        wr(3'd0, 8'h00);
        rd_now(3'd3, w);
        check(w <= v && v - w <= 1, "R10 count kept over mode write", w, v);

        // R3/R11: timer 2 on divided tick, latch 0 and 5.
        wr(3'd0, 8'h0A);
        wr(3'd2, 8'd0);
        measure(n);
        check(n == 16, "R3 period latch0", n, 16);
        wr(3'd2, 8'd5);
        measure(n);
        check(n == 96, "R11 toggle interval", n, 96);

        // R10: source change keeps the timer 2 latch (5): cascade t1=3.
        wr(3'd0, 8'h02);
        measure(n);
        exp = cascade_period(3, 5, 1'b0, 16);
        check(n == exp, "R10 latch kept after source change", n, exp);

        // R4: timer 1 on sub-clock edges, timer 2 cascaded.
        sub_run = 1'b1;
        wr(3'd0, 8'h22);
        wr(3'd1, 8'd2);
        wr(3'd2, 8'd1);
        measure(n);
        exp = cascade_period(2, 1, 1'b0, 10);
        check(n == exp, "R4 sub-clock source", n, exp);

        // R6: low-speed prescaler counts sub-clock edges.
        low_speed = 1'b1;
        wr(3'd0, 8'h0A);
        wr(3'd2, 8'd2);
        measure(n);
        check(n == 480, "R6 low-speed divided tick", n, 480);
        low_speed = 1'b0;

        // R8/R9: direct write then latch-only write.
        wr(3'd2, 8'd9);
        measure(n);
        check(n == 160, "R8 direct write period", n, 160);
        wr(3'd0, 8'h0E);
        @(negedge clk);
        rd_now(3'd2, v);
        while (v < 2) begin
            @(negedge clk);
            rd_now(3'd2, v);
        end
        addr = 3'd2; wdata = 8'd3; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_now(3'd2, w);
        check((w == v || w == v - 1) && w != 3, "R9 counter untouched", w, v);
        measure(n);
        check(n == 64, "R9 new latch after underflow", n, 64);

        // R12: disabled output is low; start level follows bit 0.
        wr(3'd0, 8'h08);
        wr(3'd2, 8'd0);
        repeat (40) @(negedge clk);
        check(tout == 1'b0, "R12 disabled low", int'(tout), 0);
        wr(3'd2, 8'd200);
        wr(3'd0, 8'h0A);
        check(tout == 1'b1, "R12 start high", int'(tout), 1);
        wr(3'd0, 8'h08);
        wr(3'd0, 8'h0B);
        check(tout == 1'b0, "R12 start low", int'(tout), 0);

        // R5/R11: seeded random cascade configurations.
        for (int k = 0; k < 8; k++) begin
            int l1, l2;
            bit sel;
            l1 = int'($urandom_range(0, 5));
            l2 = int'($urandom_range(0, 5));
            sel = 1'($urandom_range(0, 1));
            wr(3'd0, 8'h02 | (8'(sel) << 3));
            wr(3'd1, 8'(l1));
            wr(3'd2, 8'(l2));
            measure(n);
            exp = cascade_period(l1, l2, sel, 16);
            check(n == exp, "R5 random cascade", n, exp);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule